// File: doc/BRIEF.md
# SIMD Shift-Right-Accumulate Unit

This block executes the shift-right-by-immediate family of packed-integer operations on a 128-bit vector. It takes a 32-bit instruction word, a source vector and the current destination vector. It decodes the lane width and the shift count from one packed immediate field. Each source lane is widened as signed or unsigned, an optional rounding constant is added, and the lane is shifted right. The low lane-width bits of that result are then added, modulo the lane width, either to the matching destination lane or to zero.

Two forms are decoded. The vector form works on 64 or 128 bits of data split into 8-, 16-, 32- or 64-bit lanes. The scalar form works on a single 64-bit lane. Encodings that belong to another instruction class, and encodings that are undefined, are reported on two separate flags and return an all-zero result. Results appear one clock after `valid_in` is sampled high, qualified by `valid_out`, and are held while no new operation arrives.

Top module: `simd_shr_acc`

## Requirements
- R1: In the vector form (instr[28]=0), the lane width is 8 << p, where p is the index of the highest set bit of the immediate high nibble instr[22:19]. This gives 8, 16, 32 or 64 bits.
- R2: The shift count is twice the lane width minus the unsigned value of the 7-bit field {instr[22:19], instr[18:16]}. It ranges from 1 up to the lane width.
- R3: When instr[29]=1, source lanes are zero-extended. When instr[29]=0, they are sign-extended, and the shift is arithmetic.
- R4: When instr[13]=1, 2^(shift-1) is added to the widened lane before the shift, and the carry out of the lane width is kept. When instr[13]=0, the result is truncated.
- R5: When instr[12]=1, the low lane-width bits of the shifted value are added to the matching destination lane. When instr[12]=0, they are added to zero. The sum wraps modulo 2^lane-width.
- R6: In the vector form, instr[30]=1 processes all 128 bits. instr[30]=0 processes only the low 64 bits and drives result[127:64] to zero.
- R7: In the vector form, an immediate high nibble of 0000 sets `other_out`, clears `undef_out` and returns a zero result.
- R8: In the vector form, instr[22]=1 together with instr[30]=0 sets `undef_out` and returns a zero result.
- R9: instr[28]=1 selects the scalar form. It requires instr[30]=1 and instr[22]=1, otherwise `undef_out` is set. When defined, it processes one 64-bit lane, shifts by 128 minus the 7-bit immediate, and zeroes result[127:64].
- R10: `valid_out` equals `valid_in` delayed by one cycle. The result and both flags are updated only when `valid_in` was high and hold otherwise.
- R11: While `rst` is high, `valid_out`, `result`, `undef_out` and `other_out` are all zero after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operation present on the inputs this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Packed source vector |
| dst_vec | input | 128 | Packed current destination vector (accumulator) |
| valid_out | output | 1 | Registered result is new this cycle |
| result | output | 128 | Registered packed result vector |
| undef_out | output | 1 | Encoding is undefined |
| other_out | output | 1 | Encoding belongs to another instruction class |

## Verification
Rounding and accumulation can act on the same lane in the same cycle. This is the case that exposes a lost rounding carry or a missing wrap. The bench provokes it on purpose:
- with all-ones unsigned lanes shifted by the full lane width, where only the rounding carry survives;
- with a shift of one added onto all-ones destination lanes, so that the sum must wrap;
- with several hundred random encodings where both control bits are drawn freely.

Each outcome is judged lane by lane against a wide-integer reference model in the bench. The directed cases are also compared with constants worked out by hand.

// File: rtl/simd_shr_pkg.sv
package simd_shr_pkg;

    localparam int VEC_W    = 128;
    localparam int HALF_W   = VEC_W / 2;
    localparam int IMM_W    = 7;
    localparam int SHAMT_W  = 7;
    localparam int N_SIZES  = 4;
    localparam int MIN_LANE = 8;

    typedef enum logic [1:0] {
        LANE8  = 2'd0,
        LANE16 = 2'd1,
        LANE32 = 2'd2,
        LANE64 = 2'd3
    } lane_size_e;

    typedef struct packed {
        lane_size_e           size;
        logic [SHAMT_W-1:0]   shamt;
        logic                 is_uns;
        logic                 rnd;
        logic                 acc;
        logic                 full;
        logic                 undef;
        logic                 other;
    } shr_ctl_t;

    function automatic lane_size_e size_from_nibble(input logic [3:0] hi);
        lane_size_e s;
        if (hi[3])      s = LANE64;
        else if (hi[2]) s = LANE32;
        else if (hi[1]) s = LANE16;
        else            s = LANE8;
        return s;
    endfunction

    function automatic logic [8:0] twice_width(input lane_size_e s);
        return 9'(MIN_LANE * 2) << s;
    endfunction

endpackage

// File: rtl/shr_decode.sv
module shr_decode
    import simd_shr_pkg::*;
(
    input  logic [31:0] instr,
    output shr_ctl_t    ctl
);
    logic [3:0]       imm_hi;
    logic [2:0]       imm_lo;
    logic [IMM_W-1:0] imm7;
    logic             scalar_f;
    logic             wide_q;
    lane_size_e       size_w;
    logic [8:0]       shamt_full;
    logic             unused_bits;

    assign imm_hi   = instr[22:19];
    assign imm_lo   = instr[18:16];
    assign imm7     = {imm_hi, imm_lo};
    assign scalar_f = instr[28];
    assign wide_q   = instr[30];

    always_comb begin
        size_w     = scalar_f ? LANE64 : size_from_nibble(imm_hi);
        shamt_full = twice_width(size_w) - {2'b00, imm7};

        ctl.size   = size_w;
        ctl.shamt  = shamt_full[SHAMT_W-1:0];
        ctl.is_uns = instr[29];
        ctl.rnd    = instr[13];
        ctl.acc    = instr[12];
        ctl.full   = !scalar_f && wide_q;
        ctl.other  = !scalar_f && (imm_hi == 4'b0000);
        if (scalar_f)
            ctl.undef = !wide_q || !imm_hi[3];
        else
            ctl.undef = imm_hi[3] && !wide_q;
    end

    assign unused_bits = ^{instr[31], instr[27:23], instr[15:14],
                           instr[11:0], shamt_full[8:7]};

endmodule

// File: rtl/shr_lane.sv
module shr_lane
    import simd_shr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]       src_lane,
    input  logic [W-1:0]       dst_lane,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               is_uns,
    input  logic               rnd,
    input  logic               acc,
    output logic [W-1:0]       res_lane
);
    localparam int XW = W + 2;

    logic              sign_b;
    logic signed [XW-1:0] widened;
    logic signed [XW-1:0] bias;
    logic signed [XW-1:0] biased;
    logic [W-1:0]      shifted;
    logic [W-1:0]      addend;

    always_comb begin
        sign_b  = !is_uns && src_lane[W-1];
        widened = {{2{sign_b}}, src_lane};
        bias    = rnd ? (XW'(1) <<< (shamt - SHAMT_W'(1))) : '0;
        biased  = widened + bias;
        shifted = W'(biased >>> shamt);
        addend  = acc ? dst_lane : '0;
        res_lane = addend + shifted;
    end

endmodule

// File: rtl/shr_select.sv
module shr_select
    import simd_shr_pkg::*;
(
    input  logic [VEC_W-1:0] vec8,
    input  logic [VEC_W-1:0] vec16,
    input  logic [VEC_W-1:0] vec32,
    input  logic [VEC_W-1:0] vec64,
    input  shr_ctl_t         ctl,
    output logic [VEC_W-1:0] out_vec
);
    logic [VEC_W-1:0] picked;

    always_comb begin
        unique case (ctl.size)
            LANE8:   picked = vec8;
            LANE16:  picked = vec16;
            LANE32:  picked = vec32;
            default: picked = vec64;
        endcase
        if (ctl.undef || ctl.other)
            out_vec = '0;
        else if (!ctl.full)
            out_vec = {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
        else
            out_vec = picked;
    end

endmodule

// File: rtl/simd_shr_acc.sv
module simd_shr_acc
    import simd_shr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [31:0]       instr,
    input  logic [VEC_W-1:0]  src_vec,
    input  logic [VEC_W-1:0]  dst_vec,
    output logic              valid_out,
    output logic [VEC_W-1:0]  result,
    output logic              undef_out,
    output logic              other_out
);
    shr_ctl_t         ctl;
    logic [VEC_W-1:0] per_size [N_SIZES];
    logic [VEC_W-1:0] next_res;

    shr_decode u_dec (
        .instr (instr),
        .ctl   (ctl)
    );

    for (genvar k = 0; k < N_SIZES; k++) begin : g_size
        localparam int LW = MIN_LANE << k;
        localparam int NL = VEC_W / LW;
        logic [VEC_W-1:0] vec;
        for (genvar e = 0; e < NL; e++) begin : g_lane
            shr_lane #(.W(LW)) u_lane (
                .src_lane (src_vec[e*LW +: LW]),
                .dst_lane (dst_vec[e*LW +: LW]),
                .shamt    (ctl.shamt),
                .is_uns   (ctl.is_uns),
                .rnd      (ctl.rnd),
                .acc      (ctl.acc),
                .res_lane (vec[e*LW +: LW])
            );
        end
        assign per_size[k] = vec;
    end

    shr_select u_sel (
        .vec8    (per_size[0]),
        .vec16   (per_size[1]),
        .vec32   (per_size[2]),
        .vec64   (per_size[3]),
        .ctl     (ctl),
        .out_vec (next_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            result    <= '0;
            undef_out <= 1'b0;
            other_out <= 1'b0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                result    <= next_res;
                undef_out <= ctl.undef;
                other_out <= ctl.other;
            end
        end
    end

endmodule

// File: rtl/simd_shr_acc_chk.sv
module simd_shr_acc_chk (
    input logic         clk,
    input logic         rst,
    input logic         valid_in,
    input logic [31:0]  instr,
    input logic         valid_out,
    input logic [127:0] result,
    input logic         undef_out,
    input logic         other_out
);
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    a_r10_idle_low: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);

    a_r10_hold_result: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> $stable(result));

    a_r7_other_class: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !instr[28] && instr[22:19] == 4'b0000) |=> (other_out && !undef_out));

    a_r8_wide_lane_half: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !instr[28] && instr[22] && !instr[30]) |=> undef_out);

    a_r9_scalar_top_bit: assert property (@(posedge clk) disable iff (rst)
        (valid_in && instr[28] && !instr[22]) |=> undef_out);

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !instr[30]) |=> (result[127:64] == 64'd0));

    a_r7_flagged_zero: assert property (@(posedge clk) disable iff (rst)
        (undef_out || other_out) |-> (result == 128'd0));

endmodule

bind simd_shr_acc simd_shr_acc_chk u_chk (.*);

// File: tb/tb_simd_shr_acc.sv
`timescale 1ns/1ps
module tb_simd_shr_acc;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_in = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_vec = '0;
    logic [127:0] dst_vec = '0;
    logic         valid_out;
    logic [127:0] result;
    logic         undef_out;
    logic         other_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    simd_shr_acc dut (.*);

    function automatic logic [31:0] mk(input bit q, input bit u, input bit sc,
                                       input logic [3:0] hi, input logic [2:0] lo,
                                       input bit o1, input bit o0);
        logic [31:0] w = 32'h0F00_0400;
        w[30] = q; w[29] = u; w[28] = sc;
        w[22:19] = hi; w[18:16] = lo; w[13] = o1; w[12] = o0;
        return w;
    endfunction

    task automatic ref_model(input logic [31:0] ins, input logic [127:0] s, d,
                             output logic [127:0] r, output bit ud, output bit ot);
        logic [3:0] hi = ins[22:19];
        int imm = int'({ins[22:19], ins[18:16]});
        bit sc = ins[28], q = ins[30];
        int w, sh, n;
        r  = '0;
        ot = !sc && (hi == 4'd0);
        ud = sc ? (!q || !hi[3]) : (hi[3] && !q);
        if (ud || ot) return;
        if (sc || hi[3]) w = 64;
        else if (hi[2])  w = 32;
        else if (hi[1])  w = 16;
        else             w = 8;
        sh = 2 * w - imm;
        n  = (sc || !q) ? 64 / w : 128 / w;
        for (int e = 0; e < n; e++) begin
            logic [63:0] a = '0, b = '0, y;
            logic signed [71:0] x;
            for (int i = 0; i < w; i++) begin
                a[i] = s[e*w + i];
                b[i] = d[e*w + i];
            end
            x = {8'd0, a};
            if (!ins[29] && a[w-1]) x = x | (~72'd0 << w);
            if (ins[13]) x = x + (72'sd1 <<< (sh - 1));
            x = x >>> sh;
            y = x[63:0] + (ins[12] ? b : 64'd0);
            for (int i = 0; i < w; i++) r[e*w + i] = y[i];
        end
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [127:0] s, d,
                       input string tag);
        logic [127:0] er;
        bit eu, eo;
        ref_model(ins, s, d, er, eu, eo);
        @(negedge clk);
        instr = ins; src_vec = s; dst_vec = d; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        chk(tag, "valid_out", 128'(valid_out), 128'd1);
        chk(tag, "result", result, er);
        chk(tag, "undef_out", 128'(undef_out), 128'(eu));
        chk(tag, "other_out", 128'(other_out), 128'(eo));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] keep;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11", "valid_out", 128'(valid_out), 128'd0);
        chk("R11", "result", result, 128'd0);
        chk("R11", "flags", 128'({undef_out, other_out}), 128'd0);
        rst = 1'b0;

        // R1 lane width 16, shift 9
        run(mk(1, 0, 0, 4'b0010, 3'b111, 0, 0), rnd128(), rnd128(), "R1");
        run(mk(1, 1, 0, 4'b0101, 3'b010, 0, 1), rnd128(), rnd128(), "R1");
        // R2 full-width shift per size
        for (int k = 0; k < 4; k++)
            run(mk(1, 0, 0, 4'(1 << k), 3'b000, 0, 0), rnd128(), rnd128(), "R2");
        // R3 signed vs unsigned on 0x80 lanes, shift 1
        run(mk(1, 0, 0, 4'b0001, 3'b111, 0, 0), {16{8'h80}}, '0, "R3");
        chk("R3", "signed lanes", result, {16{8'hC0}});
        run(mk(1, 1, 0, 4'b0001, 3'b111, 0, 0), {16{8'h80}}, '0, "R3");
        chk("R3", "unsigned lanes", result, {16{8'h40}});
        // R4 rounding carry at full-width shift
        run(mk(1, 1, 0, 4'b0001, 3'b000, 1, 0), {16{8'hFF}}, '0, "R4");
        chk("R4", "carry kept", result, {16{8'h01}});
        run(mk(1, 0, 0, 4'b0001, 3'b000, 1, 0), {16{8'h80}}, '0, "R4");
        chk("R4", "signed round", result, 128'd0);
        // R5 accumulate wrap
        run(mk(1, 1, 0, 4'b0001, 3'b111, 0, 1), {16{8'hFF}}, {16{8'hFF}}, "R5");
        chk("R5", "wrap", result, {16{8'h7E}});
        run(mk(1, 1, 1, 4'b1000, 3'b000, 1, 1), {2{64'hFFFF_FFFF_FFFF_FFFF}},
            {2{64'hFFFF_FFFF_FFFF_FFFF}}, "R5");
        chk("R5", "64-bit round+acc", result, {64'd0, 64'd0});
        // R6 half width
        run(mk(0, 0, 0, 4'b0011, 3'b101, 1, 1), rnd128(), rnd128(), "R6");
        chk("R6", "upper half", result[127:64], 128'd0);
        // R7 other class
        run(mk(1, 0, 0, 4'b0000, 3'b101, 1, 1), rnd128(), rnd128(), "R7");
        // R8 undefined
        run(mk(0, 0, 0, 4'b1010, 3'b001, 0, 1), rnd128(), rnd128(), "R8");
        // R9 scalar forms
        run(mk(1, 0, 1, 4'b1100, 3'b011, 1, 1), rnd128(), rnd128(), "R9");
        run(mk(1, 0, 1, 4'b0111, 3'b011, 0, 0), rnd128(), rnd128(), "R9");
        run(mk(0, 1, 1, 4'b1111, 3'b111, 0, 1), rnd128(), rnd128(), "R9");
        // R10 hold while idle
        run(mk(1, 0, 0, 4'b0100, 3'b000, 1, 1), rnd128(), rnd128(), "R10");
        keep = result;
        instr = mk(1, 1, 0, 4'b0001, 3'b000, 0, 0);
        src_vec = rnd128(); dst_vec = rnd128();
        @(negedge clk);
        chk("R10", "idle valid_out", 128'(valid_out), 128'd0);
        chk("R10", "held result", result, keep);

        // random mix
        for (int t = 0; t < 400; t++) begin
            logic [31:0] ins = $urandom;
            string tag;
            ins[28] = ($urandom % 4 == 0);
            if (ins[28]) begin
                ins[30] = ($urandom % 8 != 0);
                ins[22] = ($urandom % 8 != 0);
            end else begin
                ins[30] = ($urandom % 4 != 0);
                if ($urandom % 16 == 0) ins[22:19] = 4'd0;
            end
            if (ins[28]) tag = "R9";
            else if (ins[22:19] == 4'd0) tag = "R7";
            else if (ins[22] && !ins[30]) tag = "R8";
            else if (!ins[30]) tag = "R6";
            else tag = "R5";
            run(ins, rnd128(), rnd128(), tag);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule